// File: doc/BRIEF.md
# Speculative Result Buffer with Dual In-Order Retirement

This block keeps the results of instructions that have executed ahead of time until they can safely change architectural state. Issue logic claims one slot per instruction, in program order, and receives the slot index back as the tag that the producing unit later attaches to its result. Results arrive out of order on a single broadcast port and are parked in their slot. Issue logic can also use the lookup ports to read a result that has completed but not yet retired.

Retirement works from the oldest slot. Each cycle up to two consecutive completed slots leave the buffer. Each produces a register write, a memory store request or, for a branch, nothing. A branch whose prediction proved wrong does not retire when it becomes the oldest slot. Instead it discards every slot and reports the correct fetch address, so that fetch can restart.

Top module: `rob_top`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready_o` is 1, `alloc_tag_o` is 0, and `retire_o`, `rf_we_o`, `st_we_o` and `flush_o` are all 0.
- R2: A slot is claimed on a clock edge only when `alloc_valid_i`, `rs_free_i` and `alloc_ready_o` are all 1. Tags are handed out consecutively from 0 and wrap from 7 to 0. With either request input low, `alloc_tag_o` stays the same.
- R3: After eight claims with no retirement, `alloc_ready_o` is 0 and further claims are dropped. One retirement makes `alloc_ready_o` 1 again in the following cycle.
- R4: A broadcast to an occupied slot stores the value, the store address and the mispredict flag, and marks the slot complete. A broadcast to an unoccupied slot has no effect, and the slot still reads not-complete once it is later claimed.
- R5: Only the oldest slot may retire first. A younger completed slot never retires while an older slot is incomplete.
- R6: When the two oldest slots are both complete and neither is a wrong branch, both retire in the same cycle. Bit 0 of each retire-port vector is the older of the two.
- R7: Kind encoding is 2'b00 register write, 2'b01 store, 2'b10 branch. A retiring register slot drives `rf_we_o` with its destination and value. A retiring store drives `st_we_o` with its address and data. A retiring branch whose prediction held raises only `retire_o`.
- R8: A complete branch flagged mispredicted in the oldest slot raises `flush_o` for one cycle, with `redirect_pc_o` equal to its broadcast value. No slot retires and `alloc_ready_o` is 0 in that cycle. In the next cycle the buffer is empty, `alloc_tag_o` is 0 and no older tag reads complete.
- R9: The second retire port is used only if the first port retires in the same cycle. A wrong branch in the second position does not leave alongside the older slot; it flushes one cycle later.
- R10: Lookup port p reports complete, with the stored value, for an occupied slot whose result has arrived and not yet retired. For a slot still waiting on its result it reports not complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Issue requests a slot |
| rs_free_i | input | 1 | A reservation station is free for this issue |
| alloc_kind_i | input | 2 | Kind of instruction being issued |
| alloc_dest_i | input | 5 | Destination register number |
| alloc_ready_o | output | 1 | A slot can be claimed this cycle |
| alloc_tag_o | output | 3 | Tag the next claim receives |
| wb_valid_i | input | 1 | Result broadcast valid |
| wb_tag_i | input | 3 | Slot the result belongs to |
| wb_value_i | input | 32 | Result, store data or correct branch target |
| wb_addr_i | input | 32 | Store address |
| wb_mispred_i | input | 1 | Branch outcome differs from prediction |
| lkp_tag_i | input | 6 | Two lookup tags, port p at bits [3p+2:3p] |
| lkp_ready_o | output | 2 | Lookup hit on a completed slot, per port |
| lkp_value_o | output | 64 | Lookup values, port p at bits [32p+31:32p] |
| retire_o | output | 2 | Slot leaves the buffer, per retire port |
| rf_we_o | output | 2 | Register write enable, per retire port |
| rf_waddr_o | output | 10 | Register write address, 5 bits per port |
| rf_wdata_o | output | 64 | Register write data, 32 bits per port |
| st_we_o | output | 2 | Store request, per retire port |
| st_addr_o | output | 64 | Store address, 32 bits per port |
| st_data_o | output | 64 | Store data, 32 bits per port |
| flush_o | output | 1 | Discard all slots and restart fetch |
| redirect_pc_o | output | 32 | Correct fetch address during a flush |

## Verification
Results are broadcast youngest-first, oldest-first and interleaved. The youngest-first case shows that completion order does not leak into retirement. Releasing only the oldest result shows whether the second port waits for the first. Completing two neighbours together shows whether dual retirement fires. A run that fills all eight slots and then drains them covers pointer wrap and the full limit. A wrong branch placed second, with completed younger entries behind it, shows that the older entry still leaves, that nothing younger escapes and that the flush comes one cycle later. A correct branch shows that it leaves silently.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    KIND_REG    = 2'b00,
    KIND_STORE  = 2'b01,
    KIND_BRANCH = 2'b10
  } rob_kind_e;
endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 2,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_fire_i,
  input  logic [CNT_W-1:0] retire_cnt_i,
  input  logic             flush_i,
  output logic [IDX_W-1:0] head_idx_o,
  output logic [IDX_W-1:0] tail_idx_o,
  output logic             full_o
);
  logic [PTR_W-1:0] head_q, tail_q, count_w;

  // extra msb separates full from empty
  assign count_w    = tail_q - head_q;
  assign full_o     = (count_w == PTR_W'(DEPTH));
  assign head_idx_o = head_q[IDX_W-1:0];
  assign tail_idx_o = tail_q[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
    end else if (flush_i) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_q + PTR_W'(retire_cnt_i);
      tail_q <= tail_q + PTR_W'(alloc_fire_i);
    end
  end

  assert_count_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_w <= PTR_W'(DEPTH));
  assert_flush_empties_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (head_q == '0) && (tail_q == '0));
endmodule

// File: rtl/rob_store.sv
module rob_store
  import rob_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int DATA_W   = 32,
  parameter int REG_W    = 5,
  parameter int RETIRE_W = 2,
  parameter int LKP_N    = 2,
  localparam int IDX_W   = $clog2(DEPTH)
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                alloc_fire_i,
  input  logic [IDX_W-1:0]                    alloc_idx_i,
  input  rob_kind_e                           alloc_kind_i,
  input  logic [REG_W-1:0]                    alloc_dest_i,
  input  logic                                wb_valid_i,
  input  logic [IDX_W-1:0]                    wb_tag_i,
  input  logic [DATA_W-1:0]                   wb_value_i,
  input  logic [DATA_W-1:0]                   wb_addr_i,
  input  logic                                wb_mispred_i,
  input  logic [IDX_W-1:0]                    head_idx_i,
  input  logic [RETIRE_W-1:0]                 retire_i,
  input  logic                                flush_i,
  input  logic [LKP_N-1:0][IDX_W-1:0]         lkp_tag_i,
  output logic [LKP_N-1:0]                    lkp_ready_o,
  output logic [LKP_N-1:0][DATA_W-1:0]        lkp_value_o,
  output logic [RETIRE_W-1:0]                 rd_valid_o,
  output logic [RETIRE_W-1:0]                 rd_ready_o,
  output logic [RETIRE_W-1:0]                 rd_mispred_o,
  output rob_kind_e [RETIRE_W-1:0]            rd_kind_o,
  output logic [RETIRE_W-1:0][REG_W-1:0]      rd_dest_o,
  output logic [RETIRE_W-1:0][DATA_W-1:0]     rd_value_o,
  output logic [RETIRE_W-1:0][DATA_W-1:0]     rd_addr_o
);
  logic [DEPTH-1:0]  valid_q, ready_q, mispred_q;
  rob_kind_e         kind_q  [DEPTH];
  logic [REG_W-1:0]  dest_q  [DEPTH];
  logic [DATA_W-1:0] value_q [DEPTH];
  logic [DATA_W-1:0] addr_q  [DEPTH];
  logic              wb_hit;

  assign wb_hit = wb_valid_i && valid_q[wb_tag_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= '0;
      ready_q   <= '0;
      mispred_q <= '0;
    end else if (flush_i) begin
      valid_q <= '0;
      ready_q <= '0;
    end else begin
      for (int k = 0; k < RETIRE_W; k++) begin
        if (retire_i[k]) begin
          valid_q[IDX_W'(head_idx_i + IDX_W'(k))] <= 1'b0;
          ready_q[IDX_W'(head_idx_i + IDX_W'(k))] <= 1'b0;
        end
      end
      if (alloc_fire_i) begin
        valid_q[alloc_idx_i]   <= 1'b1;
        ready_q[alloc_idx_i]   <= 1'b0;
        mispred_q[alloc_idx_i] <= 1'b0;
      end
      if (wb_hit) begin
        ready_q[wb_tag_i]   <= 1'b1;
        mispred_q[wb_tag_i] <= wb_mispred_i;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (alloc_fire_i) begin
      kind_q[alloc_idx_i] <= alloc_kind_i;
      dest_q[alloc_idx_i] <= alloc_dest_i;
    end
    if (wb_hit) begin
      value_q[wb_tag_i] <= wb_value_i;
      addr_q[wb_tag_i]  <= wb_addr_i;
    end
  end

  for (genvar p = 0; p < LKP_N; p++) begin : g_lkp
    assign lkp_ready_o[p] = valid_q[lkp_tag_i[p]] & ready_q[lkp_tag_i[p]];
    assign lkp_value_o[p] = value_q[lkp_tag_i[p]];
  end

  for (genvar k = 0; k < RETIRE_W; k++) begin : g_rd
    logic [IDX_W-1:0] idx;
    assign idx             = IDX_W'(head_idx_i + IDX_W'(k));
    assign rd_valid_o[k]   = valid_q[idx];
    assign rd_ready_o[k]   = ready_q[idx];
    assign rd_mispred_o[k] = mispred_q[idx];
    assign rd_kind_o[k]    = kind_q[idx];
    assign rd_dest_o[k]    = dest_q[idx];
    assign rd_value_o[k]   = value_q[idx];
    assign rd_addr_o[k]    = addr_q[idx];
  end

  assert_wb_marks_ready_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_hit && !flush_i) |=> ready_q[$past(wb_tag_i)]);
  assert_wb_stray_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_i && !valid_q[wb_tag_i]) |=> !ready_q[$past(wb_tag_i)]);
endmodule

// File: rtl/rob_retire.sv
module rob_retire
  import rob_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int REG_W    = 5,
  parameter int RETIRE_W = 2,
  localparam int CNT_W   = $clog2(RETIRE_W + 1)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [RETIRE_W-1:0]             rd_valid_i,
  input  logic [RETIRE_W-1:0]             rd_ready_i,
  input  logic [RETIRE_W-1:0]             rd_mispred_i,
  input  rob_kind_e [RETIRE_W-1:0]        rd_kind_i,
  input  logic [RETIRE_W-1:0][REG_W-1:0]  rd_dest_i,
  input  logic [RETIRE_W-1:0][DATA_W-1:0] rd_value_i,
  input  logic [RETIRE_W-1:0][DATA_W-1:0] rd_addr_i,
  output logic [RETIRE_W-1:0]             retire_o,
  output logic [CNT_W-1:0]                retire_cnt_o,
  output logic [RETIRE_W-1:0]             rf_we_o,
  output logic [RETIRE_W-1:0][REG_W-1:0]  rf_waddr_o,
  output logic [RETIRE_W-1:0][DATA_W-1:0] rf_wdata_o,
  output logic [RETIRE_W-1:0]             st_we_o,
  output logic [RETIRE_W-1:0][DATA_W-1:0] st_addr_o,
  output logic [RETIRE_W-1:0][DATA_W-1:0] st_data_o,
  output logic                            flush_o,
  output logic [DATA_W-1:0]               redirect_pc_o
);
  logic [RETIRE_W:0]   chain;
  logic [RETIRE_W-1:0] wrong_br;

  assign chain[0] = 1'b1;

  // a slot leaves only behind a slot that leaves
  for (genvar k = 0; k < RETIRE_W; k++) begin : g_slot
    assign wrong_br[k]   = (rd_kind_i[k] == KIND_BRANCH) && rd_mispred_i[k];
    assign retire_o[k]   = chain[k] & rd_valid_i[k] & rd_ready_i[k] & ~wrong_br[k];
    assign chain[k+1]    = retire_o[k];
    assign rf_we_o[k]    = retire_o[k] && (rd_kind_i[k] == KIND_REG);
    assign st_we_o[k]    = retire_o[k] && (rd_kind_i[k] == KIND_STORE);
    assign rf_waddr_o[k] = rd_dest_i[k];
    assign rf_wdata_o[k] = rd_value_i[k];
    assign st_addr_o[k]  = rd_addr_i[k];
    assign st_data_o[k]  = rd_value_i[k];
    if (k > 0) begin : g_chk
      assert_second_needs_first_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        retire_o[k] |-> retire_o[k-1]);
    end
  end

  always_comb begin
    retire_cnt_o = '0;
    for (int k = 0; k < RETIRE_W; k++) retire_cnt_o = retire_cnt_o + CNT_W'(retire_o[k]);
  end

  assign flush_o       = rd_valid_i[0] & rd_ready_i[0] & wrong_br[0];
  assign redirect_pc_o = rd_value_i[0];

  assert_flush_no_retire_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> (retire_o == '0));
  assert_single_effect_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rf_we_o[0] | st_we_o[0]) && ((rf_we_o & st_we_o) == '0));
endmodule

// File: rtl/rob_top.sv
module rob_top
  import rob_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int DATA_W   = 32,
  parameter int REG_W    = 5,
  parameter int RETIRE_W = 2,
  parameter int LKP_N    = 2,
  localparam int IDX_W   = $clog2(DEPTH)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       alloc_valid_i,
  input  logic                       rs_free_i,
  input  logic [1:0]                 alloc_kind_i,
  input  logic [REG_W-1:0]           alloc_dest_i,
  output logic                       alloc_ready_o,
  output logic [IDX_W-1:0]           alloc_tag_o,
  input  logic                       wb_valid_i,
  input  logic [IDX_W-1:0]           wb_tag_i,
  input  logic [DATA_W-1:0]          wb_value_i,
  input  logic [DATA_W-1:0]          wb_addr_i,
  input  logic                       wb_mispred_i,
  input  logic [LKP_N*IDX_W-1:0]     lkp_tag_i,
  output logic [LKP_N-1:0]           lkp_ready_o,
  output logic [LKP_N*DATA_W-1:0]    lkp_value_o,
  output logic [RETIRE_W-1:0]        retire_o,
  output logic [RETIRE_W-1:0]        rf_we_o,
  output logic [RETIRE_W*REG_W-1:0]  rf_waddr_o,
  output logic [RETIRE_W*DATA_W-1:0] rf_wdata_o,
  output logic [RETIRE_W-1:0]        st_we_o,
  output logic [RETIRE_W*DATA_W-1:0] st_addr_o,
  output logic [RETIRE_W*DATA_W-1:0] st_data_o,
  output logic                       flush_o,
  output logic [DATA_W-1:0]          redirect_pc_o
);
  localparam int CNT_W = $clog2(RETIRE_W + 1);

  logic                            alloc_fire, full;
  logic [IDX_W-1:0]                head_idx, tail_idx;
  logic [CNT_W-1:0]                retire_cnt;
  logic [RETIRE_W-1:0]             rd_valid, rd_ready, rd_mispred;
  rob_kind_e [RETIRE_W-1:0]        rd_kind;
  logic [RETIRE_W-1:0][REG_W-1:0]  rd_dest;
  logic [RETIRE_W-1:0][DATA_W-1:0] rd_value, rd_addr;

  assign alloc_ready_o = ~full & ~flush_o;
  assign alloc_fire    = alloc_valid_i & rs_free_i & alloc_ready_o;
  assign alloc_tag_o   = tail_idx;

  rob_ptr_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ptr (
    .clk_i, .rst_ni,
    .alloc_fire_i (alloc_fire),
    .retire_cnt_i (retire_cnt),
    .flush_i      (flush_o),
    .head_idx_o   (head_idx),
    .tail_idx_o   (tail_idx),
    .full_o       (full)
  );

  rob_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .REG_W(REG_W),
              .RETIRE_W(RETIRE_W), .LKP_N(LKP_N)) u_store (
    .clk_i, .rst_ni,
    .alloc_fire_i (alloc_fire),
    .alloc_idx_i  (tail_idx),
    .alloc_kind_i (rob_kind_e'(alloc_kind_i)),
    .alloc_dest_i (alloc_dest_i),
    .wb_valid_i, .wb_tag_i, .wb_value_i, .wb_addr_i, .wb_mispred_i,
    .head_idx_i   (head_idx),
    .retire_i     (retire_o),
    .flush_i      (flush_o),
    .lkp_tag_i    (lkp_tag_i),
    .lkp_ready_o  (lkp_ready_o),
    .lkp_value_o  (lkp_value_o),
    .rd_valid_o   (rd_valid),
    .rd_ready_o   (rd_ready),
    .rd_mispred_o (rd_mispred),
    .rd_kind_o    (rd_kind),
    .rd_dest_o    (rd_dest),
    .rd_value_o   (rd_value),
    .rd_addr_o    (rd_addr)
  );

  rob_retire #(.DATA_W(DATA_W), .REG_W(REG_W), .RETIRE_W(RETIRE_W)) u_retire (
    .clk_i, .rst_ni,
    .rd_valid_i    (rd_valid),
    .rd_ready_i    (rd_ready),
    .rd_mispred_i  (rd_mispred),
    .rd_kind_i     (rd_kind),
    .rd_dest_i     (rd_dest),
    .rd_value_i    (rd_value),
    .rd_addr_i     (rd_addr),
    .retire_o      (retire_o),
    .retire_cnt_o  (retire_cnt),
    .rf_we_o       (rf_we_o),
    .rf_waddr_o    (rf_waddr_o),
    .rf_wdata_o    (rf_wdata_o),
    .st_we_o       (st_we_o),
    .st_addr_o     (st_addr_o),
    .st_data_o     (st_data_o),
    .flush_o       (flush_o),
    .redirect_pc_o (redirect_pc_o)
  );

  assert_tag_advances_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_fire |=> alloc_tag_o == IDX_W'($past(alloc_tag_o) + 1'b1));
  assert_tag_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(alloc_valid_i && rs_free_i) && !flush_o) |=> $stable(alloc_tag_o));
endmodule

// File: tb/rob_top_tb_top.sv
module rob_top_tb_top;
  localparam int IW = 3;
  localparam int DW = 32;
  localparam int RW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          alloc_valid = 0, rs_free = 0, wb_valid = 0, wb_mispred = 0;
  logic [1:0]    alloc_kind = 0;
  logic [RW-1:0] alloc_dest = 0;
  logic [IW-1:0] wb_tag = 0;
  logic [DW-1:0] wb_value = 0, wb_addr = 0;
  logic [2*IW-1:0] lkp_tag = 0;
  logic          alloc_ready, flush;
  logic [IW-1:0] alloc_tag;
  logic [1:0]    lkp_ready, retire, rf_we, st_we;
  logic [63:0]   lkp_value, rf_wdata, st_addr, st_data;
  logic [9:0]    rf_waddr;
  logic [DW-1:0] redirect_pc;

  rob_top dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .alloc_valid_i(alloc_valid), .rs_free_i(rs_free), .alloc_kind_i(alloc_kind),
    .alloc_dest_i(alloc_dest), .alloc_ready_o(alloc_ready), .alloc_tag_o(alloc_tag),
    .wb_valid_i(wb_valid), .wb_tag_i(wb_tag), .wb_value_i(wb_value),
    .wb_addr_i(wb_addr), .wb_mispred_i(wb_mispred),
    .lkp_tag_i(lkp_tag), .lkp_ready_o(lkp_ready), .lkp_value_o(lkp_value),
    .retire_o(retire), .rf_we_o(rf_we), .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata),
    .st_we_o(st_we), .st_addr_o(st_addr), .st_data_o(st_data),
    .flush_o(flush), .redirect_pc_o(redirect_pc)
  );

  typedef struct {
    logic [1:0]    kind;
    logic [RW-1:0] dest;
    logic [DW-1:0] value;
    logic [DW-1:0] addr;
    logic          mispred;
  } item_t;

  item_t exp_q[$];
  item_t tab[8];
  item_t mon_e;
  logic [IW-1:0] tb_tail = 0;
  int n_run = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    alloc_valid = 0;
    wb_valid    = 0;
  endtask

  task automatic alloc(input logic [1:0] k, input logic [RW-1:0] d,
                       input logic [DW-1:0] v, input logic [DW-1:0] a, input logic m);
    item_t it;
    it.kind = k; it.dest = d; it.value = v; it.addr = a; it.mispred = m;
    chk(alloc_ready == 1'b1, "R3 ready before claim", alloc_ready, 1);
    chk(alloc_tag == tb_tail, "R2 tag sequence", alloc_tag, tb_tail);
    tab[tb_tail] = it;
    exp_q.push_back(it);
    tb_tail++;
    alloc_valid = 1; alloc_kind = k; alloc_dest = d;
    step();
  endtask

  task automatic wb(input logic [IW-1:0] t);
    wb_valid = 1; wb_tag = t;
    wb_value = tab[t].value; wb_addr = tab[t].addr; wb_mispred = tab[t].mispred;
    step();
  endtask

  // scoreboard monitor: outputs depend on state only, sampled between edges
  always @(negedge clk) begin
    if (rst_n) begin
      chk(((rf_we | st_we) & ~retire) == 2'b00, "R7 write without retire", {rf_we, st_we}, 0);
      for (int k = 0; k < 2; k++) begin
        if (retire[k]) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R5 retire with nothing outstanding", k, 0);
          end else begin
            mon_e = exp_q.pop_front();
            chk(rf_we[k] == (mon_e.kind == 2'b00), "R7 reg write enable", rf_we[k], mon_e.kind == 2'b00);
            chk(st_we[k] == (mon_e.kind == 2'b01), "R7 store enable", st_we[k], mon_e.kind == 2'b01);
            if (mon_e.kind == 2'b00) begin
              chk(rf_waddr[k*RW +: RW] == mon_e.dest, "R7 reg address", rf_waddr[k*RW +: RW], mon_e.dest);
              chk(rf_wdata[k*DW +: DW] == mon_e.value, "R7 reg data", rf_wdata[k*DW +: DW], mon_e.value);
            end else if (mon_e.kind == 2'b01) begin
              chk(st_addr[k*DW +: DW] == mon_e.addr, "R7 store address", st_addr[k*DW +: DW], mon_e.addr);
              chk(st_data[k*DW +: DW] == mon_e.value, "R7 store data", st_data[k*DW +: DW], mon_e.value);
            end else begin
              chk(!mon_e.mispred, "R8 wrong branch retired", 1, 0);
            end
          end
        end
      end
      if (flush) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 flush with nothing outstanding", 1, 0);
        end else begin
          mon_e = exp_q[0];
          chk(mon_e.kind == 2'b10 && mon_e.mispred, "R8 flush source", mon_e.kind, 2);
          chk(redirect_pc == mon_e.value, "R8 redirect", redirect_pc, mon_e.value);
          exp_q.delete();
        end
      end
    end
  end

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0;
    #9;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(alloc_ready == 1, "R1 ready", alloc_ready, 1);
    chk(alloc_tag == 0, "R1 tag", alloc_tag, 0);
    chk({retire, rf_we, st_we, flush} == 0, "R1 quiet outputs", {retire, rf_we, st_we, flush}, 0);

    // R2 no claim without a free reservation station
    alloc_valid = 1; rs_free = 0;
    step();
    chk(alloc_tag == 0, "R2 gated by rs_free", alloc_tag, 0);
    rs_free = 1;

    // youngest result first
    alloc(2'b00, 5'd3, 32'h111, 32'h0, 0);
    alloc(2'b01, 5'd0, 32'h222, 32'h40, 0);
    alloc(2'b00, 5'd7, 32'h333, 32'h0, 0);
    lkp_tag = {3'd0, 3'd2};
    wb(2);
    chk(lkp_ready == 2'b01, "R10 lookup readiness", lkp_ready, 2'b01);
    chk(lkp_value[31:0] == 32'h333, "R10 lookup value", lkp_value[31:0], 32'h333);
    chk(retire == 0, "R5 younger held back", retire, 0);
    wb(0);
    chk(retire == 2'b01, "R9 second port waits", retire, 2'b01);
    wb(1);
    chk(retire == 2'b11, "R6 dual retire", retire, 2'b11);
    step();
    chk(retire == 0 && alloc_tag == 3, "R6 drained", {retire, alloc_tag}, 3);

    // R4 stray broadcast to unoccupied slot 5
    wb_valid = 1; wb_tag = 5; wb_value = 32'hdead; wb_addr = 0; wb_mispred = 0;
    step();
    alloc(2'b00, 5'd1, 32'ha1, 0, 0);
    alloc(2'b00, 5'd2, 32'ha2, 0, 0);
    alloc(2'b00, 5'd4, 32'ha4, 0, 0);
    lkp_tag = {3'd4, 3'd5};
    chk(lkp_ready == 2'b00, "R4 stray result ignored", lkp_ready, 0);
    wb(5);
    chk(lkp_ready[0] == 1 && lkp_value[31:0] == 32'ha4, "R4 result stored", lkp_value[31:0], 32'ha4);
    wb(3);
    chk(retire == 2'b01, "R9 blocked second slot", retire, 2'b01);
    wb(4);
    chk(retire == 2'b11, "R6 dual retire after wrap", retire, 2'b11);
    step();

    // R3 fill all slots, tags wrap 6,7,0..5
    for (int i = 0; i < 8; i++) alloc(2'b00, 5'(i + 8), 32'h1000 + i, 0, 0);
    chk(alloc_ready == 0, "R3 full", alloc_ready, 0);
    alloc_valid = 1; alloc_kind = 0; alloc_dest = 5'd31;
    step();
    chk(alloc_tag == tb_tail && alloc_ready == 0, "R3 claim dropped when full", alloc_tag, tb_tail);
    wb(6);
    chk(retire == 2'b01 && alloc_ready == 0, "R3 still full while retiring", {retire, alloc_ready}, 2);
    step();
    chk(alloc_ready == 1, "R3 space after retire", alloc_ready, 1);
    for (int i = 0; i < 7; i++) wb(3'(7 + i));
    step(); step();
    chk(exp_q.size() == 0, "R5 all retired in order", exp_q.size(), 0);

    // R8 and R9 wrong branch in second position; tail is 6
    alloc(2'b00, 5'd9, 32'h900, 0, 0);
    alloc(2'b10, 5'd0, 32'h1000_0040, 0, 1);
    alloc(2'b00, 5'd10, 32'h901, 0, 0);
    alloc(2'b01, 5'd0, 32'h902, 32'h80, 0);
    wb(0);
    wb(1);
    chk(retire == 0, "R5 younger complete, oldest not", retire, 0);
    wb(7);
    chk(retire == 0 && flush == 0, "R8 branch not yet oldest", {retire, flush}, 0);
    wb(6);
    chk(retire == 2'b01 && flush == 0, "R9 wrong branch stays behind", {retire, flush}, 2'b010);
    step();
    chk(flush == 1 && retire == 0, "R8 flush raised", {flush, retire}, 3'b100);
    chk(redirect_pc == 32'h1000_0040, "R8 redirect value", redirect_pc, 32'h1000_0040);
    chk(alloc_ready == 0, "R8 no claim during flush", alloc_ready, 0);
    step();
    tb_tail = 0;
    lkp_tag = {3'd1, 3'd0};
    chk(flush == 0 && alloc_tag == 0 && alloc_ready == 1, "R8 empty after flush", {flush, alloc_tag, alloc_ready}, 1);
    chk(lkp_ready == 0, "R8 younger results discarded", lkp_ready, 0);
    chk(retire == 0, "R8 nothing retires after flush", retire, 0);

    // R7 correct branch leaves silently
    alloc(2'b10, 5'd0, 32'h77, 0, 0);
    alloc(2'b00, 5'd2, 32'h55, 0, 0);
    wb(0);
    chk(retire == 2'b01 && rf_we == 0 && st_we == 0, "R7 silent branch", {retire, rf_we, st_we}, 6'b010000);
    wb(1);
    chk(rf_we == 2'b01, "R7 reg after branch", rf_we, 2'b01);
    step(); step();
    chk(exp_q.size() == 0, "R5 final drain", exp_q.size(), 0);
    finish_run();
  end
endmodule